// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the 28 word-wide control registers of a host bridge and serves them on a simple register bus. The window is 0x70 bytes long. The register bus delivers byte offsets that are already relative to the window base. A register is chosen by its word index, which is the offset shifted right by two. The bus carries only full 32-bit words. An access of any other size, or one that is not word-aligned, is dropped.

Most registers simply hold whatever software writes. The interrupt-enable register is an exception: it changes only through a write-one-to-set alias and a write-one-to-clear alias. Both the enable register and the interrupt status register are read-only. When software raises bit 2 of the general configuration register from 0 to 1, the block emits a one-cycle system-reset request. The block also drives the interrupt routing logic elsewhere in the chip with the edge-select, steering, polarity and enable registers.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset the registers hold these values, with all other registers zero: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000.
- R2: A write to the set alias (offset 0x30) stores the data in 0x30 and ORs the data into the enable register (0x38).
- R3: A write to the clear alias (offset 0x34) stores the data in 0x34 and clears, in the enable register, every bit that is 1 in the data.
- R4: Writes to the enable register (0x38) and the status register (0x3C) change nothing. The status register reads zero.
- R5: A write to offset 0x04 whose data has bit 2 set, while the stored bit 2 is 0, pulses sys_reset_req high for exactly one cycle. The pulse appears in the cycle after the write. The data is stored in every case. A write that leaves bit 2 at 1, or that writes it as 0, produces no pulse.
- R6: An access is accepted only when req_size is 2 (word) and req_addr[1:0] is 0. A rejected write changes nothing. A rejected read returns zero.
- R7: Offsets 0x70 and above are unmapped. Writes there are ignored and reads return zero.
- R8: All other offsets from 0x00 to 0x6C are plain read/write. A write takes effect at the clock edge that samples it. rsp_valid and rsp_rdata follow one cycle after req_rd, and a read that coincides with a write returns the old value.
- R9: int_edge_o, int_steer_o, int_pol_o and int_en_o always equal the registers at 0x24, 0x28, 0x2C and 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write request |
| req_rd | input | 1 | Read request |
| req_addr | input | 7 | Byte offset within the window |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after req_rd |
| rsp_rdata | output | 32 | Read data |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| int_edge_o | output | 32 | Interrupt edge/level select register |
| int_steer_o | output | 32 | Interrupt steering register |
| int_pol_o | output | 32 | Interrupt polarity register |
| int_en_o | output | 32 | Interrupt enable register |

## Verification
The reset request is the hardest behaviour to reach. Bit 2 of the configuration register comes out of reset already set, so a pulse needs two writes: first one that clears the bit, then one that sets it. Directed steps walk through the 1→1, 1→0 and 0→1 cases in turn. The random phase then aims about a quarter of its writes at offset 0x04 with random data, which produces many more clear-then-set pairs. In that phase the bench also checks that every pulse matches its model's view of the old bit.

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs #(
  parameter int DW    = 32,
  parameter int NREGS = 28,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sys_reset_req,
  output logic [DW-1:0] int_edge_o,
  output logic [DW-1:0] int_steer_o,
  output logic [DW-1:0] int_pol_o,
  output logic [DW-1:0] int_en_o
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] IDX_GEN   = IW'(1);
  localparam logic [IW-1:0] IDX_EDGE  = IW'(9);
  localparam logic [IW-1:0] IDX_STEER = IW'(10);
  localparam logic [IW-1:0] IDX_POL   = IW'(11);
  localparam logic [IW-1:0] IDX_SET   = IW'(12);
  localparam logic [IW-1:0] IDX_CLR   = IW'(13);
  localparam logic [IW-1:0] IDX_EN    = IW'(14);
  localparam logic [IW-1:0] IDX_STAT  = IW'(15);
  localparam int RST_BIT = 2;

  function automatic logic [DW-1:0] init_val(input int i);
    case (i)
      0:       return DW'(32'h0000_0C40);
      1:       return DW'(32'h0000_1384);
      2:       return DW'(32'h2BFF_8010);
      3:       return DW'(32'h255E_0091);
      4:       return DW'(32'h0000_6140);
      7, 8:    return DW'(32'h0000_01FF);
      26:      return DW'(32'h0000_0008);
      27:      return DW'(32'h1000_0000);
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] regs [NREGS];

  wire [IW-1:0] idx    = req_addr[AW-1:2];
  wire          acc_ok = (req_size == 2'd2) && (req_addr[1:0] == 2'b00) && (int'(idx) < NREGS);
  wire          wr_ok  = req_wr && acc_ok;
  wire          rd_ok  = req_rd && acc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= init_val(i);
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      sys_reset_req <= 1'b0;
    end else begin
      rsp_valid     <= req_rd;
      rsp_rdata     <= rd_ok ? regs[idx] : '0;
      sys_reset_req <= wr_ok && (idx == IDX_GEN) && !regs[IDX_GEN][RST_BIT] && req_wdata[RST_BIT];
      if (wr_ok) begin
        case (idx)
          IDX_EN, IDX_STAT: ;
          IDX_SET: begin
            regs[IDX_SET] <= req_wdata;
            regs[IDX_EN]  <= regs[IDX_EN] | req_wdata;
          end
          IDX_CLR: begin
            regs[IDX_CLR] <= req_wdata;
            regs[IDX_EN]  <= regs[IDX_EN] & ~req_wdata;
          end
          default: regs[idx] <= req_wdata;
        endcase
      end
    end
  end

  assign int_edge_o  = regs[IDX_EDGE];
  assign int_steer_o = regs[IDX_STEER];
  assign int_pol_o   = regs[IDX_POL];
  assign int_en_o    = regs[IDX_EN];

  AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && idx == IDX_SET) |=> ((int_en_o & $past(req_wdata)) == $past(req_wdata))); // R2
  AST_CLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && idx == IDX_CLR) |=> ((int_en_o & $past(req_wdata)) == '0)); // R3
  AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && (idx == IDX_SET || idx == IDX_CLR)) |=> $stable(int_en_o)); // R4
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req); // R5
  AST_RST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && idx == IDX_GEN) |=> !sys_reset_req); // R5
  AST_REJECT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_size != 2'd2) |=> !sys_reset_req); // R6
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rsp_valid); // R8
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rsp_valid); // R8
endmodule

// File: tb/bridge_ctrl_regs_tb.sv
`timescale 1ns/1ps
module bridge_ctrl_regs_tb;
  localparam real CLK_NS = 20.0;
  logic clk = 0, rst_n = 0;
  logic req_wr = 0, req_rd = 0;
  logic [6:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, sys_reset_req;
  logic [31:0] rsp_rdata, int_edge_o, int_steer_o, int_pol_o, int_en_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m [28];

  always #(CLK_NS/2) clk = ~clk;

  bridge_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sys_reset_req(sys_reset_req), .int_edge_o(int_edge_o), .int_steer_o(int_steer_o),
    .int_pol_o(int_pol_o), .int_en_o(int_en_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_m(input int i);
    case (i)
      0: return 32'hC40;       1: return 32'h1384;
      2: return 32'h2BFF8010;  3: return 32'h255E0091;
      4: return 32'h6140;      7: return 32'h1FF;
      8: return 32'h1FF;       26: return 32'h8;
      27: return 32'h10000000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit accepted(input logic [6:0] a, input logic [1:0] s);
    return s == 2'd2 && a[1:0] == 2'b00 && a < 7'h70;
  endfunction

  function automatic logic [31:0] exp_read(input logic [6:0] a, input logic [1:0] s);
    return accepted(a, s) ? m[a >> 2] : 32'h0;
  endfunction

  task automatic model_write(input logic [6:0] a, input logic [1:0] s, input logic [31:0] d,
                             output bit pulse);
    int i;
    pulse = 0;
    if (!accepted(a, s)) return;
    i = int'(a >> 2);
    pulse = (i == 1) && !m[1][2] && d[2];
    case (i)
      14, 15: ;
      12: begin m[12] = d; m[14] = m[14] | d; end
      13: begin m[13] = d; m[14] = m[14] & ~d; end
      default: m[i] = d;
    endcase
  endtask

  task automatic check_routing();
    chk("R9 edge", int_edge_o, m[9]);
    chk("R9 steer", int_steer_o, m[10]);
    chk("R9 pol", int_pol_o, m[11]);
    chk("R9 enable", int_en_o, m[14]);
  endtask

  task automatic wr(input logic [6:0] a, input logic [1:0] s, input logic [31:0] d);
    bit p;
    @(negedge clk);
    req_wr = 1; req_addr = a; req_size = s; req_wdata = d;
    model_write(a, s, d, p);
    @(negedge clk);
    req_wr = 0;
    chk("R5 reset pulse", {31'h0, sys_reset_req}, {31'h0, p});
  endtask

  task automatic rd(input logic [6:0] a, input logic [1:0] s, input string req);
    @(negedge clk);
    req_rd = 1; req_addr = a; req_size = s;
    @(negedge clk);
    req_rd = 0;
    chk({req, " valid"}, {31'h0, rsp_valid}, 32'h1);
    chk(req, rsp_rdata, exp_read(a, s));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 28; i++) m[i] = init_m(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R5 idle after reset", {31'h0, sys_reset_req}, 32'h0);
    chk("R8 no rsp after reset", {31'h0, rsp_valid}, 32'h0);
    for (int i = 0; i < 28; i++) rd(7'(i * 4), 2'd2, "R1 reset value");
    check_routing();

    // R2 / R3 aliases
    wr(7'h30, 2'd2, 32'h0000_00F5);
    rd(7'h38, 2'd2, "R2 enable after set");
    rd(7'h30, 2'd2, "R2 set stored");
    wr(7'h30, 2'd2, 32'h0001_0002);
    rd(7'h38, 2'd2, "R2 enable ORed");
    wr(7'h34, 2'd2, 32'h0000_0011);
    rd(7'h38, 2'd2, "R3 enable cleared");
    rd(7'h34, 2'd2, "R3 clear stored");
    check_routing();

    // R4 read-only registers
    wr(7'h38, 2'd2, 32'hFFFF_FFFF);
    rd(7'h38, 2'd2, "R4 enable unchanged");
    wr(7'h3C, 2'd2, 32'hDEAD_BEEF);
    rd(7'h3C, 2'd2, "R4 status zero");

    // R5 reset request sequence: bit2 starts at 1
    wr(7'h04, 2'd2, 32'h0000_0004);
    wr(7'h04, 2'd2, 32'h0000_0000);
    wr(7'h04, 2'd2, 32'h0000_0004);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'h0, sys_reset_req}, 32'h0);
    rd(7'h04, 2'd2, "R5 value stored");

    // R6 size and alignment
    wr(7'h40, 2'd0, 32'h1111_1111);
    wr(7'h40, 2'd1, 32'h2222_2222);
    wr(7'h42, 2'd2, 32'h3333_3333);
    rd(7'h40, 2'd2, "R6 rejected writes");
    rd(7'h40, 2'd1, "R6 halfword read zero");
    wr(7'h04, 2'd2, 32'h0);
    wr(7'h04, 2'd0, 32'h4);
    rd(7'h04, 2'd2, "R6 byte write to config dropped");

    // R7 unmapped
    wr(7'h70, 2'd2, 32'hCAFE_F00D);
    rd(7'h70, 2'd2, "R7 unmapped read zero");
    rd(7'h7C, 2'd2, "R7 top unmapped read zero");

    // R8 plain registers, read-during-write sees old value
    wr(7'h24, 2'd2, 32'hA5A5_0001);
    wr(7'h28, 2'd2, 32'h0000_0F0F);
    wr(7'h2C, 2'd2, 32'h8000_0001);
    rd(7'h24, 2'd2, "R8 plain readback");
    check_routing();
    @(negedge clk);
    req_wr = 1; req_rd = 1; req_addr = 7'h48; req_size = 2'd2; req_wdata = 32'h7777_0000;
    @(negedge clk);
    req_wr = 0; req_rd = 0;
    chk("R8 read-during-write old", rsp_rdata, m[18]);
    m[18] = 32'h7777_0000;
    rd(7'h48, 2'd2, "R8 write landed");

    // random phase
    for (int k = 0; k < 600; k++) begin
      logic [6:0] a;
      logic [1:0] s;
      logic [31:0] d;
      int r = int'($urandom % 16);
      a = (r < 4) ? 7'h04 : (r < 7) ? 7'(7'h30 + 4 * ($urandom % 4)) : 7'(($urandom % 32) * 4);
      if ($urandom % 10 == 0) a[1:0] = 2'($urandom % 4);
      s = ($urandom % 6 == 0) ? 2'($urandom % 4) : 2'd2;
      d = $urandom;
      if ($urandom % 3 == 0) rd(a, s, "R8 random read");
      else wr(a, s, d);
      if (k % 50 == 0) check_routing();
    end
    check_routing();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule